// File: doc/BRIEF.md
# Split-Memory Accumulator CPU with Code-Space Data Access

This is a 16-bit two-register (A and D) processor with separate instruction and data memories. Its instruction set is the usual one. An address-load instruction puts a 15-bit constant into A. A compute instruction selects an ALU function, a set of destinations and a jump condition. Any instruction that names the memory operand M normally reaches data memory at A[14:0].

When A[15] is set, the same M operand reaches the instruction memory at A[14:0]. The block inserts one extra clock, phase t2, for such accesses. The instruction memory port is free during t2 to serve the data read or write. No new opcodes are needed, and programs that keep A[15] clear for their M accesses behave exactly as they would on a plain single-cycle machine.

Both memories are expected to read combinationally and to write on the rising clock edge. A single write-data bus feeds both memories, because at most one of them is written in any cycle.

Top module: `harvard_cpu`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the instruction address is 0, both write enables are low and the data address is 0. The machine starts in phase t1.
- R2: A word with bit 15 clear loads A with {0, word[14:0]}. It takes one cycle and advances the fetch address by 1.
- R3: A word with bits 15:13 = 111 is a compute instruction. Bit 12 selects the ALU's second operand (0 = A, 1 = M), bits 11:6 select the function, bits 5:3 select the destinations A, D and M, and bits 2:0 select the jump on result less than zero, equal to zero and greater than zero. The ALU functions follow the standard function table (0, 1, -1, x, y, ~x, ~y, -x, -y, x+1, y+1, x-1, y-1, x+y, x-y, y-x, x&y, x|y, with x = D).
- R4: A jump is taken when any enabled condition (bit 2 negative, bit 1 zero, bit 0 positive) matches the 16-bit two's-complement result. Otherwise the fetch address advances by 1.
- R5: An M access with A[15] = 0 goes to data memory at A[14:0] and completes in one cycle. A write drives the data write enable together with the result on the shared bus.
- R6: An M access with A[15] = 1 takes two cycles. In t1 the instruction is fetched and the fetch address is held. In t2 the instruction address is A[14:0] and the instruction completes. In the cycle after t2 the next fetch address is presented.
- R7: An M write with A[15] = 1 asserts the instruction-memory write enable in t2 only, with the result on the shared write bus. The data write enable stays low.
- R8: The data address is 0 in every cycle without a data-memory access. This includes address-load instructions, compute instructions that do not use M, and both phases of an instruction-memory access.
- R9: When a jumping instruction also writes A, the jump goes to the newly computed A value. A=M with an unconditional jump therefore jumps through a pointer, in either memory.
- R10: A read-modify-write of M with A[15] = 1 reads the instruction-memory word and writes the result back to the same address within the same two-cycle sequence.
- R11: A compute instruction that does not use M takes one cycle, even when A[15] = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pm_addr_o | output | 15 | Instruction memory address (fetch address in t1, A[14:0] in t2) |
| pm_rdata_i | input | 16 | Instruction memory read data |
| pm_we_o | output | 1 | Instruction memory write enable |
| wdata_o | output | 16 | Shared write data for both memories |
| dm_addr_o | output | 15 | Data memory address, 0 when idle |
| dm_rdata_i | input | 16 | Data memory read data |
| dm_we_o | output | 1 | Data memory write enable |

## Verification
The hardest case to reach from the ports is the t2 phase, because A[15] can only be set by arithmetic: an address load carries just 15 bits. The stimulus therefore builds the code address as D+A from a constant such as 0x4010, which yields 0x8020. The following instruction is then varied between a read, a write, a read-modify-write, a non-M compute and an indirect jump. A per-cycle trace of the addresses and enables pins down the stall, the t2 address and the next fetch address. The ALU and jump tables are swept across several operand pairs and sign cases.

// File: rtl/hcpu_pkg.sv
package hcpu_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = DATA_W - 1;

  typedef struct packed {
    logic       is_c;
    logic       sel_m;
    logic [5:0] comp;
    logic       wr_a;
    logic       wr_d;
    logic       wr_m;
    logic [2:0] jmp;
  } dec_t;
endpackage

// File: rtl/hcpu_decode.sv
module hcpu_decode
  import hcpu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] instr_i,
  output dec_t         dec_o
);
  always_comb begin
    dec_o       = '0;
    dec_o.is_c  = instr_i[W-1];
    if (instr_i[W-1]) begin
      dec_o.sel_m = instr_i[12];
      dec_o.comp  = instr_i[11:6];
      dec_o.wr_a  = instr_i[5];
      dec_o.wr_d  = instr_i[4];
      dec_o.wr_m  = instr_i[3];
      dec_o.jmp   = instr_i[2:0];
    end
  end
endmodule

// File: rtl/hcpu_alu.sv
module hcpu_alu #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [5:0]   comp_i,
  output logic [W-1:0] res_o,
  output logic         zr_o,
  output logic         ng_o
);
  logic [W-1:0] xz, xn, yz, yn, fo;

  always_comb begin
    xz    = comp_i[5] ? '0 : x_i;
    xn    = comp_i[4] ? ~xz : xz;
    yz    = comp_i[3] ? '0 : y_i;
    yn    = comp_i[2] ? ~yz : yz;
    fo    = comp_i[1] ? (xn + yn) : (xn & yn);
    res_o = comp_i[0] ? ~fo : fo;
    zr_o  = (res_o == '0);
    ng_o  = res_o[W-1];
  end
endmodule

// File: rtl/hcpu_ctrl.sv
module hcpu_ctrl #(
  parameter int unsigned AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic          take_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o,
  output logic          t2_o
);
  logic [AW-1:0] pc_q, pc_d;
  logic          t2_q;

  always_comb begin
    if (stall_i)     pc_d = pc_q;
    else if (take_i) pc_d = target_i;
    else             pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      t2_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      t2_q <= stall_i;
    end
  end

  assign pc_o = pc_q;
  assign t2_o = t2_q;
endmodule

// File: rtl/harvard_cpu.sv
module harvard_cpu
  import hcpu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] pm_addr_o,
  input  logic [DATA_W-1:0] pm_rdata_i,
  output logic              pm_we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] dm_addr_o,
  input  logic [DATA_W-1:0] dm_rdata_i,
  output logic              dm_we_o
);
  logic [DATA_W-1:0] a_q, d_q, ir_q;
  logic [DATA_W-1:0] instr, m_val, y_op, alu_res;
  logic [ADDR_W-1:0] pc_q, target;
  logic              t2_q, uses_m, code_sel, stall, exec, take, zr, ng;
  dec_t              dec;

  // t2 replays the held instruction while the code port serves the data
  assign instr = t2_q ? ir_q : pm_rdata_i;

  hcpu_decode #(.W(DATA_W)) u_dec (
    .instr_i (instr),
    .dec_o   (dec)
  );

  assign uses_m   = dec.is_c && (dec.sel_m || dec.wr_m);
  assign code_sel = a_q[DATA_W-1];
  assign stall    = !t2_q && uses_m && code_sel;
  assign exec     = !stall;
  assign m_val    = t2_q ? pm_rdata_i : dm_rdata_i;
  assign y_op     = dec.sel_m ? m_val : a_q;

  hcpu_alu #(.W(DATA_W)) u_alu (
    .x_i    (d_q),
    .y_i    (y_op),
    .comp_i (dec.comp),
    .res_o  (alu_res),
    .zr_o   (zr),
    .ng_o   (ng)
  );

  assign take = exec && dec.is_c &&
                ((dec.jmp[2] && ng) || (dec.jmp[1] && zr) || (dec.jmp[0] && !ng && !zr));
  // jump follows the freshly written A
  assign target = dec.wr_a ? alu_res[ADDR_W-1:0] : a_q[ADDR_W-1:0];

  hcpu_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stall_i  (stall),
    .take_i   (take),
    .target_i (target),
    .pc_o     (pc_q),
    .t2_o     (t2_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      d_q  <= '0;
      ir_q <= '0;
    end else begin
      if (stall) ir_q <= pm_rdata_i;
      if (exec) begin
        if (!dec.is_c)     a_q <= {1'b0, instr[ADDR_W-1:0]};
        else if (dec.wr_a) a_q <= alu_res;
        if (dec.wr_d)      d_q <= alu_res;
      end
    end
  end

  assign pm_addr_o = t2_q ? a_q[ADDR_W-1:0] : pc_q;
  assign pm_we_o   = t2_q && dec.wr_m;
  assign wdata_o   = alu_res;
  assign dm_we_o   = exec && dec.wr_m && !code_sel;
  assign dm_addr_o = (uses_m && !code_sel) ? a_q[ADDR_W-1:0] : '0;
endmodule

// File: rtl/hcpu_chk.sv
module hcpu_chk #(
  parameter int unsigned AW = 15,
  parameter int unsigned W  = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          t2_i,
  input logic [AW-1:0] pc_i,
  input logic [W-1:0]  a_i,
  input logic [AW-1:0] pm_addr_i,
  input logic          pm_we_i,
  input logic          dm_we_i,
  input logic [AW-1:0] dm_addr_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (pm_addr_i == '0 && !pm_we_i && !dm_we_i);
    end
  end

  assert_t2_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t2_i |=> !t2_i);

  assert_pc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t2_i |-> (pc_i == $past(pc_i)));

  assert_a_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t2_i |-> $stable(a_i));

  assert_pm_we_t2_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_we_i |-> t2_i);

  assert_one_writer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pm_we_i && dm_we_i));

  assert_dm_idle_t2_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t2_i |-> (dm_addr_i == '0 && !dm_we_i));
endmodule

bind harvard_cpu hcpu_chk #(.AW(hcpu_pkg::ADDR_W), .W(hcpu_pkg::DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .t2_i      (t2_q),
  .pc_i      (pc_q),
  .a_i       (a_q),
  .pm_addr_i (pm_addr_o),
  .pm_we_i   (pm_we_o),
  .dm_we_i   (dm_we_o),
  .dm_addr_i (dm_addr_o)
);

// File: tb/tb_harvard_cpu.sv
module tb_harvard_cpu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [14:0] pm_addr, dm_addr;
  logic [15:0] pm_rdata, dm_rdata, wdata;
  logic        pm_we, dm_we;

  logic [15:0] pm_mem [0:255];
  logic [15:0] dm_mem [0:255];

  logic [14:0] tr_pm  [0:31];
  logic [14:0] tr_dma [0:31];
  logic        tr_pmwe[0:31];
  logic        tr_dmwe[0:31];
  logic [15:0] tr_wd  [0:31];

  int errors = 0;
  int checks = 0;
  int ptr;

  localparam logic [5:0] C_ZERO = 6'b101010, C_ONE = 6'b111111, C_NEG1 = 6'b111010;
  localparam logic [5:0] C_D = 6'b001100, C_Y = 6'b110000, C_NEGY = 6'b110011;
  localparam logic [5:0] C_DPY = 6'b000010, C_YP1 = 6'b110111, C_DP1 = 6'b011111;

  always #2 clk = ~clk;

  harvard_cpu dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pm_addr_o  (pm_addr),
    .pm_rdata_i (pm_rdata),
    .pm_we_o    (pm_we),
    .wdata_o    (wdata),
    .dm_addr_o  (dm_addr),
    .dm_rdata_i (dm_rdata),
    .dm_we_o    (dm_we)
  );

  assign pm_rdata = pm_mem[pm_addr[7:0]];
  assign dm_rdata = dm_mem[dm_addr[7:0]];

  always @(posedge clk) begin
    if (pm_we) pm_mem[pm_addr[7:0]] <= wdata;
    if (dm_we) dm_mem[dm_addr[7:0]] <= wdata;
  end

  function automatic logic [15:0] a_ins(input int v);
    return {1'b0, 15'(v)};
  endfunction

  function automatic logic [15:0] c_ins(input logic a, input logic [5:0] comp,
                                        input logic [2:0] dst, input logic [2:0] jmp);
    return {3'b111, a, comp, dst, jmp};
  endfunction

  function automatic logic [5:0] comp_code(input int i);
    case (i)
      0: return 6'b101010;  1: return 6'b111111;  2: return 6'b111010;
      3: return 6'b001100;  4: return 6'b110000;  5: return 6'b001101;
      6: return 6'b110001;  7: return 6'b001111;  8: return 6'b110011;
      9: return 6'b011111; 10: return 6'b110111; 11: return 6'b001110;
     12: return 6'b110010; 13: return 6'b000010; 14: return 6'b010011;
     15: return 6'b000111; 16: return 6'b000000; default: return 6'b010101;
    endcase
  endfunction

  function automatic logic [15:0] ref_alu(input int i, input logic [15:0] x, input logic [15:0] y);
    case (i)
      0: return 16'd0;   1: return 16'd1;     2: return 16'hFFFF;
      3: return x;       4: return y;         5: return ~x;
      6: return ~y;      7: return 16'd0 - x; 8: return 16'd0 - y;
      9: return x + 1;  10: return y + 1;    11: return x - 1;
     12: return y - 1;  13: return x + y;    14: return x - y;
     15: return y - x;  16: return x & y;    default: return x | y;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      pm_mem[i] = 16'h0000;
      dm_mem[i] = 16'h0000;
    end
    ptr = 0;
  endtask

  task automatic emit(input logic [15:0] w);
    pm_mem[ptr] = w;
    ptr++;
  endtask

  task automatic halt();
    emit(a_ins(ptr));
    emit(c_ins(1'b0, C_ZERO, 3'b000, 3'b111));
  endtask

  // builds A = 0x8000 + 2*half in three words
  task automatic code_ptr(input int half);
    emit(a_ins(16'h4000 + half));
    emit(c_ins(1'b0, C_D | 6'b000000, 3'b010, 3'b000) & 16'hFFFF);
    pm_mem[ptr-1] = c_ins(1'b0, C_Y, 3'b010, 3'b000);  // D=A
    emit(c_ins(1'b0, C_DPY, 3'b100, 3'b000));          // A=D+A
  endtask

  task automatic run(input int n, input logic chk_reset);
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (chk_reset) begin
      chk("R1 reset pm_addr", 16'(pm_addr), 16'h0);
      chk("R1 reset we", {14'd0, pm_we, dm_we}, 16'h0);
    end
    rst_ni = 1'b1;
    for (int k = 0; k < n; k++) begin
      #0.5;
      tr_pm[k]   = pm_addr;
      tr_dma[k]  = dm_addr;
      tr_pmwe[k] = pm_we;
      tr_dmwe[k] = dm_we;
      tr_wd[k]   = wdata;
      @(negedge clk);
    end
  endtask

  initial begin
    #(400000 * 4);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] xs [0:4];
    logic [15:0] ys [0:4];
    xs[0] = 16'h0000; ys[0] = 16'h0000;
    xs[1] = 16'h0001; ys[1] = 16'hFFFF;
    xs[2] = 16'h1234; ys[2] = 16'h00F0;
    xs[3] = 16'h7FFF; ys[3] = 16'h8001;
    xs[4] = 16'h0F0F; ys[4] = 16'h0F0F;
    #1;

    // R1 R2 R5 R8: plain data write
    clear_mem();
    emit(a_ins(16'h0123));
    emit(c_ins(1'b0, C_Y, 3'b010, 3'b000));
    emit(a_ins(9));
    emit(c_ins(1'b0, C_D, 3'b001, 3'b000));
    halt();
    run(10, 1'b1);
    chk("R1 first fetch", 16'(tr_pm[0]), 16'h0);
    chk("R1 first dm_addr", 16'(tr_dma[0]), 16'h0);
    chk("R2 fetch advance", 16'(tr_pm[1]), 16'h1);
    chk("R8 dm_addr idle on address load", 16'(tr_dma[2]), 16'h0);
    chk("R5 dm_we", 16'(tr_dmwe[3]), 16'h1);
    chk("R5 dm_addr", 16'(tr_dma[3]), 16'h9);
    chk("R2 R5 wdata", tr_wd[3], 16'h0123);
    chk("R5 single cycle", 16'(tr_pm[4]), 16'h4);
    chk("R5 memory", dm_mem[9], 16'h0123);

    // R3: ALU sweep, y taken from M = dm[5]
    for (int v = 0; v < 5; v++) begin
      for (int i = 0; i < 18; i++) begin
        clear_mem();
        dm_mem[5] = ys[v];
        emit(a_ins(xs[v]));
        emit(c_ins(1'b0, C_Y, 3'b010, 3'b000));
        emit(a_ins(5));
        emit(c_ins(1'b1, comp_code(i), 3'b001, 3'b000));
        halt();
        run(8, 1'b0);
        chk($sformatf("R3 alu fn %0d x=%h y=%h", i, xs[v], ys[v]), dm_mem[5], ref_alu(i, xs[v], ys[v]));
      end
    end

    // R4: jump conditions vs D sign
    for (int s = 0; s < 3; s++) begin
      for (int j = 0; j < 8; j++) begin
        logic taken;
        clear_mem();
        emit(a_ins(5));
        if (s == 0)      emit(c_ins(1'b0, C_Y, 3'b010, 3'b000));
        else if (s == 1) emit(c_ins(1'b0, C_ZERO, 3'b010, 3'b000));
        else             emit(c_ins(1'b0, C_NEGY, 3'b010, 3'b000));
        emit(a_ins(20));
        emit(c_ins(1'b0, C_D, 3'b000, 3'(j)));
        emit(a_ins(6));
        emit(c_ins(1'b0, C_ONE, 3'b001, 3'b000));
        halt();
        ptr = 20;
        emit(a_ins(6));
        emit(c_ins(1'b0, C_NEG1, 3'b001, 3'b000));
        halt();
        run(10, 1'b0);
        taken = (j[2] && s == 2) || (j[1] && s == 1) || (j[0] && s == 0);
        chk($sformatf("R4 jump j=%0d sign=%0d", j, s), dm_mem[6], taken ? 16'hFFFF : 16'h0001);
      end
    end

    // R6 R8: read from code memory
    clear_mem();
    pm_mem[8'h20] = 16'hBEEF;
    code_ptr(16'h10);
    emit(c_ins(1'b1, C_Y, 3'b010, 3'b000));   // D=M
    emit(a_ins(6));
    emit(c_ins(1'b0, C_D, 3'b001, 3'b000));
    halt();
    run(12, 1'b0);
    chk("R6 t1 fetch", 16'(tr_pm[3]), 16'h3);
    chk("R8 dm_addr in t1 of code access", 16'(tr_dma[3]), 16'h0);
    chk("R6 t2 address", 16'(tr_pm[4]), 16'h20);
    chk("R8 dm_addr in t2", 16'(tr_dma[4]), 16'h0);
    chk("R6 next fetch", 16'(tr_pm[5]), 16'h4);
    chk("R6 read value", dm_mem[6], 16'hBEEF);

    // R7 R10: read-modify-write in code memory
    clear_mem();
    pm_mem[8'h20] = 16'h00FF;
    code_ptr(16'h10);
    emit(c_ins(1'b1, C_YP1, 3'b001, 3'b000)); // M=M+1
    halt();
    run(10, 1'b0);
    chk("R7 no pm_we in t1", 16'(tr_pmwe[3]), 16'h0);
    chk("R7 pm_we in t2", 16'(tr_pmwe[4]), 16'h1);
    chk("R7 dm_we low in t2", 16'(tr_dmwe[4]), 16'h0);
    chk("R10 written value", tr_wd[4], 16'h0100);
    chk("R10 memory", pm_mem[8'h20], 16'h0100);
    chk("R6 fetch after rmw", 16'(tr_pm[5]), 16'h4);

    // R7: pure write of D into code memory
    clear_mem();
    code_ptr(16'h10);
    emit(c_ins(1'b0, C_D, 3'b001, 3'b000));   // M=D
    halt();
    run(10, 1'b0);
    chk("R7 write address", 16'(tr_pm[4]), 16'h20);
    chk("R7 write memory", pm_mem[8'h20], 16'h4010);
    chk("R7 data memory untouched", dm_mem[0], 16'h0000);

    // R11: non-M compute with A[15] set
    clear_mem();
    code_ptr(16'h10);
    emit(c_ins(1'b0, C_DP1, 3'b010, 3'b000)); // D=D+1
    emit(a_ins(6));
    emit(c_ins(1'b0, C_D, 3'b001, 3'b000));
    halt();
    run(10, 1'b0);
    chk("R11 no stall", 16'(tr_pm[4]), 16'h4);
    chk("R11 result", dm_mem[6], 16'h4011);

    // R9: indirect jump through code memory
    clear_mem();
    pm_mem[8'h30] = 16'h0040;
    code_ptr(16'h18);
    emit(c_ins(1'b1, C_Y, 3'b100, 3'b111));   // A=M;JMP
    ptr = 16'h40;
    emit(a_ins(6));
    emit(c_ins(1'b0, C_ONE, 3'b001, 3'b000));
    halt();
    run(12, 1'b0);
    chk("R9 t2 address", 16'(tr_pm[4]), 16'h30);
    chk("R9 target code", 16'(tr_pm[5]), 16'h40);
    chk("R9 marker code", dm_mem[6], 16'h0001);

    // R9: indirect jump through data memory
    clear_mem();
    dm_mem[7] = 16'h0050;
    emit(a_ins(7));
    emit(c_ins(1'b1, C_Y, 3'b100, 3'b111));
    ptr = 16'h50;
    emit(a_ins(6));
    emit(c_ins(1'b0, C_NEG1, 3'b001, 3'b000));
    halt();
    run(10, 1'b0);
    chk("R9 target data", 16'(tr_pm[2]), 16'h50);
    chk("R9 marker data", dm_mem[6], 16'hFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule